// File: doc/BRIEF.md
# Cache-Line Instruction Fetch Controller

This block is the front of an instruction pipeline. It keeps one cache line and the tag of that line. Each cycle it slices up to WIDTH consecutive 32-bit instruction words out of the line and hands them downstream, each with its PC and a running sequence number. When the PC leaves the held line, or no valid line is held, it sends a line-aligned read to the instruction cache port. It then follows the answer through a small status machine. A hit goes back to issuing. A miss waits for a fill. A fault is turned into a marked no-op and fetch stops until the next redirect.

Per cycle, issue is capped by the slots left in the downstream buffer and by the free rename-register count. Issue also stops right after a slot that the predictor marks taken, and right after a quiesce word. A fill that comes back after a redirect has cancelled the miss is dropped and flagged. A redirect from the back end sets a new PC and starts a fresh line request on the next cycle.

Top module: `ifetch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, no slot is valid, `stale_fill` is low and `fetch_state` is 0 (RUN). The first request is for the line that holds RESET_PC.
- R2: `fetch_state` codes are RUN=0, REQ=1, MISS=2, MISS_DONE=3, RENAME_BLK=4, QUIESCE=5 and TRAP=6. `req_valid` is high exactly in REQ. `req_addr` is the PC with its low log2(LINE_BYTES) bits cleared. A new request is made only when the PC lies outside the held line or the line is not valid.
- R3: Slot i carries the word at byte offset (PC & (LINE_BYTES-1)) with bits [1:0] forced to zero. Word j of `rsp_line` sits in bits [32j+31:32j]. Valid slots form a prefix from slot 0, carry consecutive PCs and sequence numbers, and all lie in one line.
- R4: The number of slots issued in a cycle is at most the smallest of WIDTH, BUF_MAX-`buf_count` and `free_regs`. When `buf_count` reaches BUF_MAX, nothing is issued.
- R5: After a slot whose `pred_taken` bit is set, no later slot issues that cycle, and fetch goes on at `pred_target`.
- R6: A response with `rsp_hit` low moves to MISS and nothing issues. `fill_valid` in MISS moves to MISS_DONE for one cycle. From there the state goes to RUN, or to RENAME_BLK if `free_regs` is 0.
- R7: A `fill_valid` seen outside MISS, or in the same cycle as a redirect, changes no state or output. It raises `stale_fill` for the next cycle only.
- R8: With `free_regs` at 0, RUN moves to RENAME_BLK without issuing. RENAME_BLK moves to RUN once `free_regs` is nonzero. The first RUN cycle after leaving RENAME_BLK, QUIESCE or MISS_DONE has no valid slot.
- R9: The word 0x7F000001 is issued and then ends issue. The state becomes QUIESCE, which makes no request until `wake` (back to RUN at the next PC) or a redirect.
- R10: A response with `rsp_fault` issues one slot 0 item: word 0x00000000, `out_fault` high, the fetch PC and the next sequence number. The state then holds TRAP until a redirect.
- R11: `redir_valid` loads `redir_pc` from any state and drops any outstanding request or miss. In the next cycle the state is REQ with `req_addr` the aligned redirect PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Line read request to the cache |
| req_addr | output | 32 | Line-aligned request address |
| rsp_valid | input | 1 | Cache answer to the current request |
| rsp_hit | input | 1 | Answer is a hit and `rsp_line` holds the line |
| rsp_fault | input | 1 | Answer reports a fetch fault |
| fill_valid | input | 1 | Miss data arrives on `rsp_line` |
| rsp_line | input | LINE_BYTES*8 | Line data for a hit or a fill |
| pred_taken | input | WIDTH | Taken prediction per candidate slot |
| pred_target | input | 32 | Target used after a taken slot |
| free_regs | input | REG_W | Free rename registers |
| buf_count | input | $clog2(BUF_MAX+1) | Downstream buffer occupancy |
| redir_valid | input | 1 | Redirect request |
| redir_pc | input | 32 | Redirect PC |
| wake | input | 1 | Leave the quiesce wait |
| out_valid | output | WIDTH | Slot valid bits |
| out_pc | output | WIDTH*32 | Slot PCs |
| out_word | output | WIDTH*32 | Slot instruction words |
| out_seq | output | WIDTH*SEQ_W | Slot sequence numbers |
| out_fault | output | 1 | Slot 0 is a fault-carrying no-op |
| fetch_state | output | 3 | Status machine code |
| stale_fill | output | 1 | A fill was discarded last cycle |

## Verification
The checks assume that the cache answers a request only while `req_valid` is high and that `fill_valid` stands for one cycle. They also assume `buf_count` never exceeds BUF_MAX and that `free_regs` follows the issue decisions of the cycle before. The stimulus answers each request within one cycle of seeing it. It changes `free_regs`, `buf_count` and the prediction inputs only while issue is stopped or before the expected items are queued. It places quiesce words at known addresses so that every stream ends at a known point, and it sends fills only when the scenario sets them up.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int          FP_ADDR_W       = 32;
    localparam int          FP_INSN_BYTES   = 4;
    localparam logic [31:0] FP_NOP_WORD     = 32'h0000_0000;
    localparam logic [31:0] FP_QUIESCE_WORD = 32'h7F00_0001;

    typedef logic [FP_ADDR_W-1:0] addr_t;
    typedef logic [31:0]          word_t;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_REQ        = 3'd1,
        ST_MISS       = 3'd2,
        ST_MISS_DONE  = 3'd3,
        ST_RENAME_BLK = 3'd4,
        ST_QUIESCE    = 3'd5,
        ST_TRAP       = 3'd6
    } fetch_st_e;

    function automatic addr_t line_align(addr_t a, int unsigned line_bytes);
        return a & ~addr_t'(line_bytes - 1);
    endfunction

endpackage

// File: rtl/fetch_line_reg.sv
module fetch_line_reg
    import fetch_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int TAG_W      = FP_ADDR_W - OFF_W,
    parameter int LINE_BITS  = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 set_valid,
    input  logic                 clear_valid,
    input  logic [TAG_W-1:0]     tag_in,
    input  logic [LINE_BITS-1:0] data_in,
    output logic [TAG_W-1:0]     tag_q,
    output logic [LINE_BITS-1:0] data_q,
    output logic                 valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (load) begin
                tag_q  <= tag_in;
                data_q <= data_in;
            end
            if (clear_valid)
                valid_q <= 1'b0;
            else if (set_valid)
                valid_q <= 1'b1;
        end
    end

endmodule

// File: rtl/fetch_issue.sv
module fetch_issue
    import fetch_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int WIDTH      = 2,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int TAG_W      = FP_ADDR_W - OFF_W,
    parameter int WORDS      = LINE_BYTES / FP_INSN_BYTES,
    parameter int CNT_W      = $clog2(WIDTH + 1)
) (
    input  logic                        en,
    input  addr_t                       pc,
    input  logic [TAG_W-1:0]            line_tag,
    input  logic [WORDS-1:0][31:0]      line_words,
    input  logic [WIDTH-1:0]            pred_taken,
    input  addr_t                       pred_target,
    input  logic [CNT_W-1:0]            limit,
    output logic [WIDTH-1:0]            fire,
    output logic [WIDTH-1:0][31:0]      slot_pc,
    output logic [WIDTH-1:0][31:0]      slot_word,
    output logic [CNT_W-1:0]            n_fire,
    output addr_t                       next_pc,
    output logic                        hit_quiesce
);

    logic [WIDTH:0]   alive;
    logic [WIDTH-1:0] is_quiesce;

    assign alive[0] = en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
        addr_t              cand;
        logic               same_line;
        logic [OFF_W-3:0]   widx;

        assign cand          = pc + addr_t'(FP_INSN_BYTES * i);
        assign same_line     = (cand[FP_ADDR_W-1:OFF_W] == line_tag);
        assign widx          = cand[OFF_W-1:2];
        assign slot_pc[i]    = cand;
        assign slot_word[i]  = line_words[widx];
        assign is_quiesce[i] = (line_words[widx] == FP_QUIESCE_WORD);
        assign fire[i]       = alive[i] && same_line && (CNT_W'(i) < limit);
        assign alive[i+1]    = fire[i] && !pred_taken[i] && !is_quiesce[i];
    end

    always_comb begin
        next_pc     = pc;
        n_fire      = '0;
        hit_quiesce = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (fire[i]) begin
                n_fire      = n_fire + CNT_W'(1);
                next_pc     = pred_taken[i] ? pred_target
                                            : slot_pc[i] + addr_t'(FP_INSN_BYTES);
                hit_quiesce = hit_quiesce | is_quiesce[i];
            end
        end
    end

endmodule

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
    import fetch_pkg::*;
#(
    parameter int    LINE_BYTES = 64,
    parameter int    WIDTH      = 2,
    parameter int    BUF_MAX    = 8,
    parameter int    SEQ_W      = 16,
    parameter int    REG_W      = 8,
    parameter addr_t RESET_PC   = 32'h0000_0000,
    parameter int    LINE_BITS  = LINE_BYTES * 8,
    parameter int    BC_W       = $clog2(BUF_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    output logic                         req_valid,
    output logic [31:0]                  req_addr,
    input  logic                         rsp_valid,
    input  logic                         rsp_hit,
    input  logic                         rsp_fault,
    input  logic                         fill_valid,
    input  logic [LINE_BITS-1:0]         rsp_line,
    input  logic [WIDTH-1:0]             pred_taken,
    input  logic [31:0]                  pred_target,
    input  logic [REG_W-1:0]             free_regs,
    input  logic [BC_W-1:0]              buf_count,
    input  logic                         redir_valid,
    input  logic [31:0]                  redir_pc,
    input  logic                         wake,
    output logic [WIDTH-1:0]             out_valid,
    output logic [WIDTH-1:0][31:0]       out_pc,
    output logic [WIDTH-1:0][31:0]       out_word,
    output logic [WIDTH-1:0][SEQ_W-1:0]  out_seq,
    output logic                         out_fault,
    output logic [2:0]                   fetch_state,
    output logic                         stale_fill
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = FP_ADDR_W - OFF_W;
    localparam int WORDS = LINE_BYTES / FP_INSN_BYTES;
    localparam int CNT_W = $clog2(WIDTH + 1);

    fetch_st_e               state, st_n;
    addr_t                   pc, pc_n, rq_n;
    logic [SEQ_W-1:0]        seq, seq_n;
    logic [WIDTH-1:0]        ov_n;
    logic [WIDTH-1:0][31:0]  opc_n, ow_n;
    logic [WIDTH-1:0][SEQ_W-1:0] oseq_n;
    logic                    of_n, stale_n;

    logic                    ln_load, ln_set, ln_clear;
    logic [TAG_W-1:0]        ln_tag;
    logic [LINE_BITS-1:0]    ln_data;
    logic                    ln_valid;
    logic                    need_line, issue_en;
    logic [CNT_W-1:0]        limit;

    logic [WIDTH-1:0]        fire;
    logic [WIDTH-1:0][31:0]  slot_pc, slot_word;
    logic [CNT_W-1:0]        n_fire;
    addr_t                   next_pc;
    logic                    hit_quiesce;

    fetch_line_reg #(.LINE_BYTES(LINE_BYTES)) u_line (
        .clk        (clk),
        .rst        (rst),
        .load       (ln_load),
        .set_valid  (ln_set),
        .clear_valid(ln_clear),
        .tag_in     (req_addr[FP_ADDR_W-1:OFF_W]),
        .data_in    (rsp_line),
        .tag_q      (ln_tag),
        .data_q     (ln_data),
        .valid_q    (ln_valid)
    );

    fetch_issue #(.LINE_BYTES(LINE_BYTES), .WIDTH(WIDTH)) u_issue (
        .en         (issue_en),
        .pc         (pc),
        .line_tag   (ln_tag),
        .line_words (ln_data),
        .pred_taken (pred_taken),
        .pred_target(pred_target),
        .limit      (limit),
        .fire       (fire),
        .slot_pc    (slot_pc),
        .slot_word  (slot_word),
        .n_fire     (n_fire),
        .next_pc    (next_pc),
        .hit_quiesce(hit_quiesce)
    );

    assign need_line = !ln_valid || (pc[FP_ADDR_W-1:OFF_W] != ln_tag);
    assign issue_en  = !redir_valid && (state == ST_RUN) && !need_line
                       && (free_regs != '0);

    always_comb begin
        int room_v;
        int lim_v;
        room_v = (int'(buf_count) >= BUF_MAX) ? 0 : BUF_MAX - int'(buf_count);
        lim_v  = WIDTH;
        if (room_v < lim_v) lim_v = room_v;
        if (int'(free_regs) < lim_v) lim_v = int'(free_regs);
        limit = CNT_W'(lim_v);
    end

    always_comb begin
        st_n     = state;
        pc_n     = pc;
        rq_n     = req_addr;
        seq_n    = seq;
        ov_n     = '0;
        opc_n    = slot_pc;
        ow_n     = slot_word;
        of_n     = 1'b0;
        ln_load  = 1'b0;
        ln_set   = 1'b0;
        ln_clear = 1'b0;
        for (int i = 0; i < WIDTH; i++)
            oseq_n[i] = seq + SEQ_W'(i);
        stale_n  = fill_valid && !(state == ST_MISS && !redir_valid);

        if (redir_valid) begin
            pc_n     = redir_pc;
            rq_n     = line_align(redir_pc, LINE_BYTES);
            st_n     = ST_REQ;
            ln_clear = 1'b1;
        end else begin
            case (state)
                ST_RUN: begin
                    if (need_line) begin
                        st_n = ST_REQ;
                        rq_n = line_align(pc, LINE_BYTES);
                    end else if (free_regs == '0) begin
                        st_n = ST_RENAME_BLK;
                    end else begin
                        ov_n  = fire;
                        pc_n  = next_pc;
                        seq_n = seq + SEQ_W'(n_fire);
                        if (hit_quiesce) st_n = ST_QUIESCE;
                    end
                end
                ST_REQ: begin
                    if (rsp_valid) begin
                        if (rsp_fault) begin
                            st_n      = ST_TRAP;
                            ov_n[0]   = 1'b1;
                            opc_n[0]  = pc;
                            ow_n[0]   = FP_NOP_WORD;
                            oseq_n[0] = seq;
                            of_n      = 1'b1;
                            seq_n     = seq + SEQ_W'(1);
                        end else if (rsp_hit) begin
                            ln_load = 1'b1;
                            ln_set  = 1'b1;
                            st_n    = ST_RUN;
                        end else begin
                            ln_clear = 1'b1;
                            st_n     = ST_MISS;
                        end
                    end
                end
                ST_MISS: begin
                    if (fill_valid) begin
                        ln_load = 1'b1;
                        st_n    = ST_MISS_DONE;
                    end
                end
                ST_MISS_DONE: begin
                    ln_set = 1'b1;
                    st_n   = (free_regs == '0) ? ST_RENAME_BLK : ST_RUN;
                end
                ST_RENAME_BLK: if (free_regs != '0) st_n = ST_RUN;
                ST_QUIESCE:    if (wake) st_n = ST_RUN;
                ST_TRAP:       st_n = ST_TRAP;
                default:       st_n = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            pc         <= RESET_PC;
            req_addr   <= '0;
            seq        <= '0;
            out_valid  <= '0;
            out_pc     <= '0;
            out_word   <= '0;
            out_seq    <= '0;
            out_fault  <= 1'b0;
            stale_fill <= 1'b0;
        end else begin
            state      <= st_n;
            pc         <= pc_n;
            req_addr   <= rq_n;
            seq        <= seq_n;
            out_valid  <= ov_n;
            out_pc     <= opc_n;
            out_word   <= ow_n;
            out_seq    <= oseq_n;
            out_fault  <= of_n;
            stale_fill <= stale_n;
        end
    end

    assign req_valid   = (state == ST_REQ);
    assign fetch_state = state;

    // Guards on the status machine and the slot outputs
    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[OFF_W-1:0] == '0));

    assert_slot_prefix_R3: assert property (@(posedge clk) disable iff (rst)
        ((out_valid & (out_valid + WIDTH'(1))) == '0));

    assert_issue_cap_R4: assert property (@(posedge clk) disable iff (rst)
        !out_fault |-> ($countones(out_valid) <= int'($past(free_regs))));

    assert_resume_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RENAME_BLK || $past(state) == ST_QUIESCE ||
         $past(state) == ST_MISS_DONE) |-> (out_valid == '0));

    assert_trap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_TRAP && !$past(redir_valid)) |-> (state == ST_TRAP));

    assert_stale_no_advance_R7: assert property (@(posedge clk) disable iff (rst)
        stale_fill |-> (state != ST_MISS_DONE));

    assert_redirect_req_R11: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (state == ST_REQ));

    for (genvar i = 1; i < WIDTH; i++) begin : g_same_line
        assert_slot_line_R3: assert property (@(posedge clk) disable iff (rst)
            out_valid[i] |-> (out_pc[i][31:OFF_W] == out_pc[0][31:OFF_W]));
    end

endmodule

// File: tb/tb_ifetch_ctrl.sv
module tb_ifetch_ctrl;

    localparam int LINE_BYTES = 64;
    localparam int WIDTH      = 2;
    localparam int BUF_MAX    = 8;
    localparam int SEQ_W      = 16;
    localparam int REG_W      = 8;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int BC_W       = $clog2(BUF_MAX + 1);
    localparam logic [31:0] QW  = 32'h7F00_0001;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic                         req_valid;
    logic [31:0]                  req_addr;
    logic                         rsp_valid = 1'b0;
    logic                         rsp_hit   = 1'b0;
    logic                         rsp_fault = 1'b0;
    logic                         fill_valid = 1'b0;
    logic [LINE_BITS-1:0]         rsp_line;
    logic [WIDTH-1:0]             pred_taken = '0;
    logic [31:0]                  pred_target = '0;
    logic [REG_W-1:0]             free_regs = 8'd100;
    logic [BC_W-1:0]              buf_count = '0;
    logic                         redir_valid = 1'b0;
    logic [31:0]                  redir_pc = '0;
    logic                         wake = 1'b0;
    logic [WIDTH-1:0]             out_valid;
    logic [WIDTH-1:0][31:0]       out_pc;
    logic [WIDTH-1:0][31:0]       out_word;
    logic [WIDTH-1:0][SEQ_W-1:0]  out_seq;
    logic                         out_fault;
    logic [2:0]                   fetch_state;
    logic                         stale_fill;

    logic [31:0] resp_addr = '0;
    logic [31:0] fill_addr = '0;
    int          mode = 0;          // 0 hit, 1 miss, 2 fault
    int          max_per = WIDTH;
    int          n_checks = 0;
    int          n_fail = 0;
    int          n_issued = 0;
    logic [SEQ_W-1:0] exp_seq = '0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0]      pc;
        logic [31:0]      word;
        logic [SEQ_W-1:0] seq;
        logic             fault;
        string            tag;
    } exp_t;
    exp_t        sb[$];
    logic [31:0] exp_req[$];

    always #2 clk = ~clk;

    function automatic bit is_q(logic [31:0] a);
        return a == 32'h78 || a == 32'h88 || a == 32'h208 || a == 32'h30C ||
               a == 32'h410 || a == 32'h604;
    endfunction

    function automatic logic [31:0] word_of(logic [31:0] a);
        return is_q(a) ? QW : {8'h5A, a[23:0]};
    endfunction

    function automatic logic [LINE_BITS-1:0] build_line(logic [31:0] base);
        logic [LINE_BITS-1:0] l;
        for (int j = 0; j < LINE_BYTES / 4; j++)
            l[j*32 +: 32] = word_of(base + 32'(4 * j));
        return l;
    endfunction

    assign rsp_line = build_line(fill_valid ? fill_addr : resp_addr);

    ifetch_ctrl #(
        .LINE_BYTES(LINE_BYTES), .WIDTH(WIDTH), .BUF_MAX(BUF_MAX),
        .SEQ_W(SEQ_W), .REG_W(REG_W)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .fill_valid(fill_valid), .rsp_line(rsp_line), .pred_taken(pred_taken),
        .pred_target(pred_target), .free_regs(free_regs), .buf_count(buf_count),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .wake(wake),
        .out_valid(out_valid), .out_pc(out_pc), .out_word(out_word),
        .out_seq(out_seq), .out_fault(out_fault), .fetch_state(fetch_state),
        .stale_fill(stale_fill)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_pc(input logic [31:0] a, input string tag);
        exp_t e;
        e.pc = a; e.word = word_of(a); e.seq = exp_seq; e.fault = 1'b0; e.tag = tag;
        sb.push_back(e);
        exp_seq++;
    endtask

    task automatic push_fault(input logic [31:0] a);
        exp_t e;
        e.pc = a; e.word = 32'h0; e.seq = exp_seq; e.fault = 1'b1; e.tag = "R10";
        sb.push_back(e);
        exp_seq++;
    endtask

    task automatic drain(input string tag);
        int k;
        k = 0;
        while (sb.size() != 0 && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(sb.size() == 0, tag, "items left in scoreboard", 32'(sb.size()), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic redirect(input logic [31:0] a);
        redir_pc    = a;
        redir_valid = 1'b1;
        @(negedge clk);
        redir_valid = 1'b0;
    endtask

    // Monitor and cache responder
    always @(negedge clk) begin
        if (!rst) begin
            check((out_valid & (out_valid + 2'd1)) == '0, "R3", "slot prefix",
                  32'(out_valid), 0);
            check($countones(out_valid) <= max_per, "R4", "slots per cycle",
                  32'($countones(out_valid)), 32'(max_per));
            for (int i = 0; i < WIDTH; i++) begin
                if (out_valid[i]) begin
                    n_issued++;
                    if (i > 0)
                        check(out_pc[i][31:6] == out_pc[0][31:6], "R3", "slot line",
                              out_pc[i], out_pc[0]);
                    if (sb.size() == 0) begin
                        check(1'b0, "R3", "unexpected slot pc", out_pc[i], 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(out_pc[i] == e.pc, e.tag, "slot pc", out_pc[i], e.pc);
                        check(out_word[i] == e.word, e.tag, "slot word", out_word[i], e.word);
                        check(out_seq[i] == e.seq, e.tag, "slot seq",
                              32'(out_seq[i]), 32'(e.seq));
                        if (i == 0)
                            check(out_fault == e.fault, e.tag, "fault flag",
                                  32'(out_fault), 32'(e.fault));
                    end
                end
            end
            if (req_valid) begin
                if (exp_req.size() == 0) begin
                    check(1'b0, "R2", "unexpected request", req_addr, 0);
                end else begin
                    logic [31:0] ea;
                    ea = exp_req.pop_front();
                    check(req_addr == ea, "R2", "request address", req_addr, ea);
                end
            end
            resp_addr = req_addr;
            rsp_valid = req_valid;
            rsp_hit   = req_valid && mode == 0;
            rsp_fault = req_valid && mode == 2;
        end
    end

    initial begin
        int k;
        k = 0;
        while (!done && k < 20000) begin
            @(posedge clk);
            k++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", k);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base_cnt;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check(fetch_state == 3'd0, "R1", "state in reset", 32'(fetch_state), 0);
            check(out_valid == '0, "R1", "slots in reset", 32'(out_valid), 0);
            check(!req_valid && !stale_fill, "R1", "req/stale in reset",
                  32'({req_valid, stale_fill}), 0);
        end
        exp_req.push_back(32'h0);
        exp_req.push_back(32'h40);
        for (int a = 0; a <= 32'h78; a += 4) push_pc(32'(a), "R3");
        rst = 1'b0;
        @(negedge clk);
        check(fetch_state == 3'd1, "R1", "first request state", 32'(fetch_state), 1);
        // R3/R9: linear stream ending at quiesce
        drain("R3");
        check(fetch_state == 3'd5, "R9", "quiesce state", 32'(fetch_state), 5);
        check(!req_valid, "R9", "no request in quiesce", 32'(req_valid), 0);

        // R9: wake resumes at next PC, crossing into a new line
        exp_req.push_back(32'h80);
        push_pc(32'h7C, "R9"); push_pc(32'h80, "R2");
        push_pc(32'h84, "R2"); push_pc(32'h88, "R9");
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check(fetch_state == 3'd0 && out_valid == '0, "R9", "wake bubble",
              32'({fetch_state, out_valid}), 0);
        drain("R9");

        // R6/R11: miss, then redirect cancels it
        mode = 1;
        exp_req.push_back(32'h100);
        redirect(32'h100);
        @(negedge clk);
        check(fetch_state == 3'd2, "R6", "miss state", 32'(fetch_state), 2);
        repeat (3) @(negedge clk);
        check(fetch_state == 3'd2 && out_valid == '0, "R6", "miss holds",
              32'(fetch_state), 2);
        mode = 0;
        exp_req.push_back(32'h200);
        push_pc(32'h200, "R11"); push_pc(32'h204, "R11"); push_pc(32'h208, "R11");
        redirect(32'h200);
        check(fetch_state == 3'd1, "R11", "redirect state", 32'(fetch_state), 1);
        drain("R11");

        // R7: late fill is discarded
        fill_addr  = 32'h100;
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        check(stale_fill == 1'b1, "R7", "stale flag", 32'(stale_fill), 1);
        check(fetch_state == 3'd5, "R7", "state unchanged", 32'(fetch_state), 5);
        @(negedge clk);
        check(stale_fill == 1'b0, "R7", "stale one cycle", 32'(stale_fill), 0);
        check(out_valid == '0, "R7", "no slots", 32'(out_valid), 0);

        // R6/R8: real fill, rename block, bubble, one slot per cycle
        mode = 1;
        exp_req.push_back(32'h300);
        redirect(32'h300);
        @(negedge clk);
        check(fetch_state == 3'd2, "R6", "second miss", 32'(fetch_state), 2);
        free_regs = 8'd0;
        max_per   = 1;
        push_pc(32'h300, "R4"); push_pc(32'h304, "R4");
        push_pc(32'h308, "R4"); push_pc(32'h30C, "R4");
        fill_addr  = 32'h300;
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        check(fetch_state == 3'd3, "R6", "miss done", 32'(fetch_state), 3);
        @(negedge clk);
        check(fetch_state == 3'd4, "R8", "rename block", 32'(fetch_state), 4);
        repeat (2) @(negedge clk);
        check(fetch_state == 3'd4 && out_valid == '0, "R8", "rename hold",
              32'(fetch_state), 4);
        free_regs = 8'd1;
        @(negedge clk);
        check(fetch_state == 3'd0 && out_valid == '0, "R8", "resume bubble",
              32'({fetch_state, out_valid}), 0);
        drain("R4");
        free_regs = 8'd100;
        @(negedge clk);
        max_per = WIDTH;

        // R5: taken prediction in slot 1
        mode = 0;
        pred_taken  = 2'b10;
        pred_target = 32'h410;
        exp_req.push_back(32'h400);
        push_pc(32'h400, "R5"); push_pc(32'h404, "R5"); push_pc(32'h410, "R5");
        redirect(32'h400);
        drain("R5");
        pred_taken = '0;

        // R10: fault response
        mode = 2;
        exp_req.push_back(32'h500);
        push_fault(32'h500);
        redirect(32'h500);
        drain("R10");
        check(fetch_state == 3'd6 && !req_valid, "R10", "trap hold",
              32'(fetch_state), 6);

        // R4: full buffer blocks issue, then one free slot
        mode = 0;
        buf_count = BC_W'(BUF_MAX);
        exp_req.push_back(32'h600);
        redirect(32'h600);
        base_cnt = n_issued;
        repeat (5) @(negedge clk);
        check(fetch_state == 3'd0, "R4", "running while full", 32'(fetch_state), 0);
        check(n_issued == base_cnt, "R4", "issued while full",
              32'(n_issued - base_cnt), 0);
        max_per = 1;
        push_pc(32'h600, "R4"); push_pc(32'h604, "R4");
        buf_count = BC_W'(BUF_MAX - 1);
        drain("R4");
        check(exp_req.size() == 0, "R2", "requests outstanding",
              32'(exp_req.size()), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule